// File: doc/BRIEF.md
# Camera Sync Edge Interrupt Unit

This unit sits at the front of a camera capture path. It watches the horizontal and vertical sync inputs and turns one chosen transition into a shared sync interrupt event. A two-bit detect mode picks both the sync line and the edge polarity. Only the chosen line can raise the event, so the two lines are never simply ORed together. Each event sets a sticky status bit. The top status bit belongs to the sync event. The lower bits latch pulses from the other capture interrupt sources.

Software clears status bits by writing ones to the clear address. An enable register masks the status bits. The masked bits are ORed and registered onto one interrupt line toward the processor, which software then demultiplexes by reading the status. Both sync inputs are asynchronous. They pass through a synchronizer chain before edge detection. A change of the detect mode blanks detection for one cycle, so the switch alone cannot create an event.

Top module: `cam_sync_irq`

## Requirements
- R1: One cycle after reset is released, `status_o`, `enable_o`, `mode_o` and `irq_o` are all zero.
- R2: The mode field is written at address 0 from write-data bits [1:0]. Its codes are: 0 = horizontal falling edge, 1 = horizontal rising edge, 2 = vertical falling edge, 3 = vertical rising edge. Only the coded edge of the coded line sets status bit 31.
- R3: The sync line that is not selected never sets status bit 31, whatever it does.
- R4: When a sync input changes just before rising clock edge k, status bit 31 is still clear after edge k+1 and is set after edge k+2.
- R5: Status bit 31 is set by a selected edge whether or not enable bit 31 is set.
- R6: A write at address 2 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value, and without such a write a set status bit stays set.
- R7: If a set event and a clear of the same status bit arrive in the same cycle, the bit stays set.
- R8: The enable register is written at address 1. `irq_o` equals the OR of (status AND enable) as it was one clock earlier.
- R9: A pulse on `src_evt[i]` sets status bit i, for i from 0 to 30.
- R10: Writing a new mode while both sync lines are steady never sets status bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync from the sensor, asynchronous |
| vsync_in | input | 1 | Vertical sync from the sensor, asynchronous |
| src_evt | input | NUM_SRC-1 | Single-cycle event pulses from the other capture interrupt sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 mode, 1 enable, 2 status clear |
| reg_wdata | input | DW | Write data |
| status_o | output | NUM_SRC | Sticky status bits; bit NUM_SRC-1 is the sync event |
| enable_o | output | NUM_SRC | Enable mask |
| mode_o | output | 2 | Current detect mode |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The assertions work on the synchronized copies of the sync lines, not on the raw pins. They assume each raw level is held long enough to pass through the chain as one clean transition. They also assume the other sources deliver their events as pulses on `src_evt`. The stimulus keeps each sync level steady for at least four cycles between changes, and it changes the mode only while both lines are quiet. The random sequence mixes every mode with every combination of line changes and with both enable states.

// File: rtl/cam_sync_irq_pkg.sv
package cam_sync_irq_pkg;

  localparam int MODE_W = 2;
  localparam int ADDR_W = 2;

  typedef enum logic [MODE_W-1:0] {
    DET_H_FALL = 2'd0,
    DET_H_RISE = 2'd1,
    DET_V_FALL = 2'd2,
    DET_V_RISE = 2'd3
  } det_mode_e;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 2'd0,
    REG_ENABLE = 2'd1,
    REG_CLEAR  = 2'd2,
    REG_NONE   = 2'd3
  } reg_addr_e;

  // mode bit 1 picks the line, mode bit 0 picks the rising polarity
  function automatic logic mode_uses_vsync(input det_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_wants_rise(input det_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/cam_sync_stage.sv
module cam_sync_stage #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cam_sync_edge_sel.sv
module cam_sync_edge_sel
  import cam_sync_irq_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      hs_s,
  input  logic      vs_s,
  input  det_mode_e mode,
  output logic      evt
);

  localparam int WARM_MAX = STAGES + 1;
  localparam int WARM_W   = $clog2(WARM_MAX + 1);

  logic              sel_now;
  logic              sel_prev;
  det_mode_e         mode_last;
  logic              mode_chg;
  logic [WARM_W-1:0] warm_cnt;
  logic              armed;

  assign sel_now  = mode_uses_vsync(mode) ? vs_s : hs_s;
  assign mode_chg = (mode != mode_last);
  assign armed    = (warm_cnt == WARM_W'(WARM_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev  <= 1'b0;
      mode_last <= DET_H_FALL;
      warm_cnt  <= '0;
    end else begin
      sel_prev  <= sel_now;
      mode_last <= mode;
      if (!armed) warm_cnt <= warm_cnt + 1'b1;
    end
  end

  always_comb begin
    evt = 1'b0;
    if (armed && !mode_chg && (sel_now != sel_prev))
      evt = (sel_now == mode_wants_rise(mode));
  end

endmodule

// File: rtl/cam_irq_regs.sv
module cam_irq_regs
  import cam_sync_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic [NUM_SRC-1:0] set_vec,
  output logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] enable,
  output det_mode_e          mode,
  output logic               irq
);

  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] status_n;
  logic               wr_mode;
  logic               wr_en;

  assign wr_mode  = reg_wr && (reg_addr == REG_MODE);
  assign wr_en    = reg_wr && (reg_addr == REG_ENABLE);
  assign clr_mask = (reg_wr && (reg_addr == REG_CLEAR)) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign status_n = (status & ~clr_mask) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      mode   <= DET_H_FALL;
      irq    <= 1'b0;
    end else begin
      status <= status_n;
      if (wr_en)   enable <= reg_wdata[NUM_SRC-1:0];
      if (wr_mode) mode   <= det_mode_e'(reg_wdata[MODE_W-1:0]);
      irq <= |(status & enable);
    end
  end

endmodule

// File: rtl/cam_sync_irq.sv
module cam_sync_irq
  import cam_sync_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DW      = 32,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hsync_in,
  input  logic               vsync_in,
  input  logic [NUM_SRC-2:0] src_evt,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] enable_o,
  output logic [1:0]         mode_o,
  output logic               irq_o
);

  logic [1:0] sync_q;
  logic       hs_s;
  logic       vs_s;
  logic       sync_evt;
  det_mode_e  mode_q;

  cam_sync_stage #(.WIDTH(2), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({vsync_in, hsync_in}),
    .q   (sync_q)
  );

  assign hs_s = sync_q[0];
  assign vs_s = sync_q[1];

  cam_sync_edge_sel #(.STAGES(STAGES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .hs_s (hs_s),
    .vs_s (vs_s),
    .mode (mode_q),
    .evt  (sync_evt)
  );

  cam_irq_regs #(.NUM_SRC(NUM_SRC), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .set_vec   ({sync_evt, src_evt}),
    .status    (status_o),
    .enable    (enable_o),
    .mode      (mode_q),
    .irq       (irq_o)
  );

  assign mode_o = mode_q;

endmodule

// File: rtl/cam_sync_irq_chk.sv
module cam_sync_irq_chk #(
  parameter int NUM_SRC = 32,
  parameter int DW      = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic [1:0]         reg_addr,
  input logic [DW-1:0]      reg_wdata,
  input logic [NUM_SRC-1:0] status_o,
  input logic [NUM_SRC-1:0] enable_o,
  input logic [1:0]         mode_o,
  input logic               irq_o,
  input logic               hs_s,
  input logic               vs_s,
  input logic               sync_evt
);

  logic clr_wr;
  assign clr_wr = reg_wr && (reg_addr == 2'd2);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_o == '0 && enable_o == '0 && mode_o == 2'd0 && !irq_o));

  // R3
  selected_line_chk: assert property (@(posedge clk) disable iff (rst)
    sync_evt |-> (mode_o[1] ? (vs_s != $past(vs_s)) : (hs_s != $past(hs_s))));

  // R2
  edge_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    sync_evt |-> ((mode_o[1] ? vs_s : hs_s) == mode_o[0]));

  // R10
  mode_switch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o != $past(mode_o)) |-> !sync_evt);

  // R5
  sync_status_set_chk: assert property (@(posedge clk) disable iff (rst)
    sync_evt |=> status_o[NUM_SRC-1]);

  // R6
  clear_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !sync_evt) |=> ((status_o[NUM_SRC-1] & $past(reg_wdata[NUM_SRC-1])) == 1'b0));

  // R6
  sticky_status_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(|(status_o & enable_o)));

endmodule

bind cam_sync_irq cam_sync_irq_chk #(.NUM_SRC(NUM_SRC), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .status_o  (status_o),
  .enable_o  (enable_o),
  .mode_o    (mode_o),
  .irq_o     (irq_o),
  .hs_s      (hs_s),
  .vs_s      (vs_s),
  .sync_evt  (sync_evt)
);

// File: tb/cam_sync_irq_test.sv
module cam_sync_irq_test;

  localparam int NUM_SRC = 32;
  localparam int DW      = 32;
  localparam int SB      = NUM_SRC - 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               hsync_in = 1'b0;
  logic               vsync_in = 1'b0;
  logic [NUM_SRC-2:0] src_evt = '0;
  logic               reg_wr = 1'b0;
  logic [1:0]         reg_addr = '0;
  logic [DW-1:0]      reg_wdata = '0;
  logic [NUM_SRC-1:0] status_o;
  logic [NUM_SRC-1:0] enable_o;
  logic [1:0]         mode_o;
  logic               irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cam_sync_irq #(.NUM_SRC(NUM_SRC), .DW(DW), .STAGES(2)) uut (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .src_evt(src_evt), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status_o(status_o), .enable_o(enable_o), .mode_o(mode_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // expected sync event from the mode code and the old/new line levels
  function automatic logic exp_evt(input logic [1:0] m, input logic oh, input logic nh,
                                   input logic ov, input logic nv);
    logic o, n;
    o = m[1] ? ov : oh;
    n = m[1] ? nv : nh;
    return (o != n) && (n == m[0]);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [1:0] m;
    logic en, oh, ov, nh, nv, e;
    void'($urandom(32'd2024));
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 status", status_o, '0);
    check("R1 enable", enable_o, '0);
    check("R1 mode", {30'd0, mode_o}, 32'd0);
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    idle(5);

    // R4 latency, mode 1: hs rising
    wr(2'd0, 32'd1);
    check("R2 mode readback", {30'd0, mode_o}, 32'd1);
    idle(3);
    hsync_in = 1'b1;
    idle(2);
    check("R4 not yet set", {31'd0, status_o[SB]}, 32'd0);
    idle(1);
    check("R4 set after third edge", {31'd0, status_o[SB]}, 32'd1);
    // R5 set with enable clear, no irq
    idle(1);
    check("R5 irq masked", {31'd0, irq_o}, 32'd0);
    // R8 enable raises irq one cycle later
    wr(2'd1, 32'h8000_0000);
    check("R8 irq not yet", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    check("R8 irq high", {31'd0, irq_o}, 32'd1);
    // R6 write zero leaves bit
    wr(2'd2, 32'h0000_0001);
    check("R6 zero bit keeps", {31'd0, status_o[SB]}, 32'd1);
    wr(2'd2, 32'h8000_0000);
    check("R6 clear", {31'd0, status_o[SB]}, 32'd0);
    idle(1);
    check("R8 irq drops", {31'd0, irq_o}, 32'd0);

    // R3 mode 3: hs activity ignored
    wr(2'd0, 32'd3);
    idle(3);
    for (int i = 0; i < 4; i++) begin
      hsync_in = ~hsync_in;
      idle(5);
    end
    check("R3 hs ignored in mode 3", {31'd0, status_o[SB]}, 32'd0);

    // R7 sync set wins over same-cycle clear
    vsync_in = 1'b1;
    idle(2);
    wr(2'd2, 32'h8000_0000);
    check("R7 sync set beats clear", {31'd0, status_o[SB]}, 32'd1);
    wr(2'd2, 32'hFFFF_FFFF);

    // R9 other source sets its bit, R7 for that bit
    src_evt[5] = 1'b1; @(negedge clk); src_evt[5] = 1'b0;
    check("R9 src bit 5", status_o, 32'h0000_0020);
    src_evt[5] = 1'b1;
    wr(2'd2, 32'h0000_0020);
    src_evt[5] = 1'b0;
    check("R7 src set beats clear", status_o, 32'h0000_0020);
    wr(2'd2, 32'hFFFF_FFFF);
    check("R6 all cleared", status_o, 32'h0);

    // R10 mode change with hs=0, vs=1 steady from hs rising to vs rising
    hsync_in = 1'b0;
    idle(5);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'd1);
    idle(4);
    wr(2'd0, 32'd3);
    idle(4);
    check("R10 no event on switch", {31'd0, status_o[SB]}, 32'd0);

    // random sweep: R2 R3 R5 R8 R10
    for (int it = 0; it < 60; it++) begin
      m  = 2'($urandom % 4);
      en = 1'($urandom % 2);
      oh = hsync_in; ov = vsync_in;
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd0, {30'd0, m});
      wr(2'd1, {en, 31'd0});
      idle(4);
      check("R10 random switch quiet", {31'd0, status_o[SB]}, 32'd0);
      nh = 1'($urandom % 2);
      nv = 1'($urandom % 2);
      hsync_in = nh; vsync_in = nv;
      idle(3);
      e = exp_evt(m, oh, nh, ov, nv);
      check("R2 R3 random status", {31'd0, status_o[SB]}, {31'd0, e});
      idle(1);
      check("R8 random irq", {31'd0, irq_o}, {31'd0, e & en});
      idle(2);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule